// File: doc/BRIEF.md
# Predicated SIMD Lane Array

This block is a compact single-instruction, multiple-data engine. One sequencer drives a row of identical datapath lanes, each of which stores one signed element. Every cycle the sequencer issues one operation code, and all lanes see that code on the same edge. Whether a lane acts on the code or holds its value is decided by its own one-bit predicate register.

The sequencer runs a fixed two-way branch kernel. It first writes each lane's predicate with the result of "element is zero or positive". Lanes whose predicate is true then take the increment branch. After that, lanes whose predicate is false take the decrement-by-two branch. The two branches run in separate cycles, so a divergent data set costs one cycle per branch. A branch that no lane takes is skipped.

The host loads all lanes in parallel while the engine is idle and pulses the start input. It then waits for the one-cycle done pulse and reads every lane back in parallel.

Top module: `simd_pred_array`

States of the sequencer: S_IDLE, S_EVAL, S_THEN, S_ELSE, S_DONE. Transitions:
- T_GO: S_IDLE to S_EVAL on start.
- T_EVAL_THEN: S_EVAL to S_THEN when any lane's predicate is true.
- T_EVAL_ELSE: S_EVAL to S_ELSE when no lane's predicate is true.
- T_THEN_ELSE: S_THEN to S_ELSE when any lane's predicate is false.
- T_THEN_DONE: S_THEN to S_DONE when no lane's predicate is false.
- T_ELSE_DONE: S_ELSE to S_DONE unconditionally.
- T_REST: S_DONE to S_IDLE unconditionally.

## Requirements
- R1: After reset, every lane reads back 0, done is 0 and busy is 0.
- R2: With busy low, a load pulse writes lane i from bits [i*16 +: 16] of load_data. The new values read back on the following cycle.
- R3: The predicate is true when the element is zero or positive (sign bit 0). Zero therefore takes the increment branch.
- R4: A lane with a true predicate ends with its element plus 1, wrapping in 16-bit two's complement (32767 becomes -32768).
- R5: A lane with a false predicate ends with its element minus 2, wrapping in 16-bit two's complement (-32768 becomes 32766, -1 becomes -3).
- R6: With both signs present, done rises three clock edges after the edge that accepts start. busy is high from the accepting edge until done falls.
- R7: When all lanes share one predicate value, the unused branch is skipped and done rises two edges after the accepting edge.
- R8: done is high for exactly one cycle. Read-back values hold afterwards until the next load.
- R9: start and load are ignored while busy is high. Such a start does not restart or lengthen the kernel, and such a load does not change any lane.
- R10: The branches are serialized. In the increment cycle, lanes with a false predicate keep their value. In the decrement cycle, lanes with a true predicate keep their value. So after the increment edge only the true lanes have changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Parallel load strobe, taken only when idle |
| load_data | input | LANES*16 | Packed lane elements, lane 0 in the low bits |
| start | input | 1 | Starts the kernel, taken only when idle |
| busy | output | 1 | Sequencer not in S_IDLE |
| done | output | 1 | One-cycle completion pulse (S_DONE) |
| rd_data | output | LANES*16 | Packed lane elements, live read-back |

## Verification
The main sweep shifts lane i by i*8192 from a common base. Over 8192 runs, every 16-bit value passes through the kernel exactly once, and every run mixes signs. This separates the two branch results and the wrap at both ends, and it exercises the divergent cycle count. Separate all-positive, all-negative and all-zero loads show whether the skip path is taken and that zero counts as positive. A directed divergent run samples the lanes between the two branch edges to show that the branches are serialized. Starts and loads issued during a run show that both are ignored while busy.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_THEN,
        S_ELSE,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_EVAL,
        OP_THEN,
        OP_ELSE
    } lane_op_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W        = 16,
    parameter int INC_STEP = 1,
    parameter int DEC_STEP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  lane_op_t     op,
    output logic [W-1:0] elem_q,
    output logic         mask_q,
    output logic         pred
);
    localparam logic [W-1:0] INC_V = W'(INC_STEP);
    localparam logic [W-1:0] DEC_V = W'(DEC_STEP);

    // zero or positive: sign bit clear
    assign pred = ~elem_q[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_q <= '0;
            mask_q <= 1'b0;
        end else if (load_en) begin
            elem_q <= load_val;
        end else begin
            unique case (op)
                OP_EVAL: mask_q <= pred;
                OP_THEN: if (mask_q)  elem_q <= elem_q + INC_V;
                OP_ELSE: if (!mask_q) elem_q <= elem_q - DEC_V;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/simd_flag_reduce.sv
module simd_flag_reduce #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] pred_vec,
    input  logic [LANES-1:0] mask_vec,
    output logic             any_pred,
    output logic             any_clear
);
    assign any_pred  = |pred_vec;
    assign any_clear = |(~mask_vec);
endmodule

// File: rtl/simd_seq.sv
module simd_seq
    import simd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       any_pred,
    input  logic       any_clear,
    output seq_state_t state_q,
    output lane_op_t   op,
    output logic       busy,
    output logic       done
);
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_EVAL;
            S_EVAL: state_d = any_pred  ? S_THEN : S_ELSE;
            S_THEN: state_d = any_clear ? S_ELSE : S_DONE;
            S_ELSE: state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        op   = OP_NOP;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_EVAL: op = OP_EVAL;
            S_THEN: op = OP_THEN;
            S_ELSE: op = OP_ELSE;
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/simd_pred_array.sv
module simd_pred_array
    import simd_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int W        = 16,
    parameter int INC_STEP = 1,
    parameter int DEC_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LANES*W-1:0] load_data,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [LANES*W-1:0] rd_data
);
    seq_state_t       state_q;
    lane_op_t         op;
    logic [LANES-1:0] pred_vec;
    logic [LANES-1:0] mask_vec;
    logic             any_pred;
    logic             any_clear;
    logic             load_en;

    assign load_en = load & ~busy;

    simd_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .any_pred  (any_pred),
        .any_clear (any_clear),
        .state_q   (state_q),
        .op        (op),
        .busy      (busy),
        .done      (done)
    );

    simd_flag_reduce #(.LANES(LANES)) red_i (
        .pred_vec  (pred_vec),
        .mask_vec  (mask_vec),
        .any_pred  (any_pred),
        .any_clear (any_clear)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_lane #(
            .W        (W),
            .INC_STEP (INC_STEP),
            .DEC_STEP (DEC_STEP)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en),
            .load_val (load_data[g*W +: W]),
            .op       (op),
            .elem_q   (rd_data[g*W +: W]),
            .mask_q   (mask_vec[g]),
            .pred     (pred_vec[g])
        );
    end
endmodule

// File: rtl/simd_pred_array_chk.sv
module simd_pred_array_chk
    import simd_pkg::*;
#(
    parameter int LANES = 8,
    parameter int W     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic               start,
    input logic               busy,
    input logic               done,
    input seq_state_t         state_q,
    input logic [LANES-1:0]   mask_vec,
    input logic [LANES*W-1:0] rd_data
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE || (state_q == S_IDLE && !load)) |=> $stable(rd_data));

    assert_busy_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL && load) |=> $stable(rd_data));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state_q != S_DONE) |=> state_q != S_EVAL);

    assert_accept_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> (busy && !done));

    assert_else_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ELSE) |=> done);

    assert_skip_else_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_THEN && (&mask_vec)) |=> done);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        assert_then_idle_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_THEN && !mask_vec[g]) |=> $stable(rd_data[g*W +: W]));
        assert_else_idle_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_ELSE && mask_vec[g]) |=> $stable(rd_data[g*W +: W]));
    end
endmodule

bind simd_pred_array simd_pred_array_chk #(.LANES(LANES), .W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .state_q  (state_q),
    .mask_vec (mask_vec),
    .rd_data  (rd_data)
);

// File: tb/simd_pred_array_tb_top.sv
module simd_pred_array_tb_top;
    localparam int LANES = 8;
    localparam int W     = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load = 1'b0;
    logic [LANES*W-1:0] load_data = '0;
    logic               start = 1'b0;
    logic               busy;
    logic               done;
    logic [LANES*W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    simd_pred_array #(.LANES(LANES), .W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data)
    );

    function automatic logic [W-1:0] ref_result(input logic [W-1:0] x);
        if (x[W-1] == 1'b0) return x + 16'd1;
        return x - 16'd2;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_vec(input logic [LANES*W-1:0] v);
        @(negedge clk);
        load = 1'b1;
        load_data = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    // run the kernel on vec; poke = issue ignored start/load while busy
    task automatic run_kernel(input logic [LANES*W-1:0] v, input bit poke, input bit chk_load);
        bit has_pos = 1'b0;
        bit has_neg = 1'b0;
        int cnt = 0;
        int exp_lat;
        load_vec(v);
        if (chk_load) check("R2 load readback", rd_data, v);
        for (int i = 0; i < LANES; i++) begin
            if (v[i*W+W-1]) has_neg = 1'b1;
            else            has_pos = 1'b1;
        end
        exp_lat = (has_pos && has_neg) ? 3 : 2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            check("R6 busy after start", busy, 1);
            start = 1'b1;
            load = 1'b1;
            load_data = ~v;
        end
        while (!done && cnt < 10) begin
            @(negedge clk);
            start = 1'b0;
            load = 1'b0;
            cnt++;
        end
        if (exp_lat == 3) check("R6 divergent latency", cnt, exp_lat);
        else              check("R7 uniform latency", cnt, exp_lat);
        for (int i = 0; i < LANES; i++)
            check(poke ? "R9 R4 R5 lane result" : "R4 R5 lane result",
                  rd_data[i*W +: W], ref_result(v[i*W +: W]));
        if (poke) begin
            start = 1'b1;  // arrives in S_DONE: ignored
            load = 1'b1;
            load_data = '0;
        end
        @(negedge clk);
        start = 1'b0;
        load = 1'b0;
        if (poke) begin
            check("R8 done one cycle", done, 0);
            check("R9 start in done ignored", busy, 0);
            for (int i = 0; i < LANES; i++)
                check("R8 R9 hold", rd_data[i*W +: W], ref_result(v[i*W +: W]));
            @(negedge clk);
            check("R9 no restart", busy, 0);
        end
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [LANES*W-1:0] v;
        repeat (3) @(negedge clk);
        check("R1 reset data", rd_data, 0);
        check("R1 reset done", done, 0);
        check("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rd_data, 0);

        // R3: all zeros -> all increment, uniform
        run_kernel('0, 1'b1, 1'b1);
        // all positive, including max
        for (int i = 0; i < LANES; i++) v[i*W +: W] = 16'(32767 - i*100);
        run_kernel(v, 1'b1, 1'b1);
        // all negative, including min and -1
        for (int i = 0; i < LANES; i++) v[i*W +: W] = (i == 0) ? 16'h8000 : 16'(-i);
        run_kernel(v, 1'b1, 1'b1);

        // R10: serialized branches, sample between the two branch edges
        for (int i = 0; i < LANES; i++) v[i*W +: W] = (i % 2 == 0) ? 16'(i*7) : 16'(-i*7);
        load_vec(v);
        start = 1'b1;
        @(negedge clk);   // S_EVAL
        start = 1'b0;
        @(negedge clk);   // S_THEN
        @(negedge clk);   // S_ELSE: increment applied only
        for (int i = 0; i < LANES; i++)
            check("R10 after increment edge", rd_data[i*W +: W],
                  (i % 2 == 0) ? 16'(v[i*W +: W] + 16'd1) : v[i*W +: W]);
        @(negedge clk);   // S_DONE
        check("R10 done", done, 1);
        for (int i = 0; i < LANES; i++)
            check("R10 after decrement edge", rd_data[i*W +: W], ref_result(v[i*W +: W]));
        @(negedge clk);

        // exhaustive sweep: every 16-bit value once, signs mixed per run
        for (int k = 0; k < 8192; k++) begin
            for (int i = 0; i < LANES; i++) v[i*W +: W] = 16'(k + i*8192);
            run_kernel(v, (k % 1024) == 5, (k % 64) == 0);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule